// File: doc/BRIEF.md
# Two-Port Root Hub Power and Status Controller

This block holds the power and status state of a two-port USB root hub. Software reaches it through a byte-wide register write port and a combinational byte-wide read port. A USB-reset strobe from the core register block also drives it. It keeps two configuration registers (port count and switching mode in A, removable and power-mask bits in B), a hub status register, and one status register per port. It carries out global and per-port power switching and the override that keeps power always on. It makes fixed, non-removable devices appear attached, and it keeps write-one-to-clear change bits.

Byte address = register index × 4 + byte lane. Register index 0 is config A, 1 is config B, 2 is hub status, and 3 + p is the status of port p. So port 0 sits at 0x0C–0x0F and port 1 at 0x10–0x13. A write is one cycle with `wr_en` high and takes effect at that clock edge. `rd_data` follows `rd_addr` in the same cycle. Unmapped bytes read as zero. This is a register interface, so it has no back-pressure. `port_power` shows each port's power bit directly.

Top module: `hub_pwr_ctrl`

## Requirements
- R1: After reset, address 0x00 reads the port count (0x02). Every other byte reads 0x00. `port_power` is 0.
- R2: Config A byte 1 (0x01) stores the written value ANDed with 0x1B. Byte 3 (0x03) stores bits 1:0. Writes to bytes 0 and 2 have no effect.
- R3: Writing config A byte 1 with bit 1 set turns on the power bit (status byte 1 bit 0) of both ports.
- R4: Config B bytes 0 (removable, 0x04) and 2 (power mask, 0x06) store only bits 2:1. Bit 1 belongs to port 0 and bit 2 to port 1. Writes to bytes 1 and 3 have no effect.
- R5: A write to 0x04 with a port's removable bit clear sets that port's connect bit (status byte 0 bit 0). It sets change bit 0 (status byte 2 bit 0) only if the port was not already connected.
- R6: Writing 1 to hub status bit 0 (0x08 bit 0) removes power from the affected ports. It also clears their connect bit and their change bits 0x17. The mode is config A byte 1 bits 1:0. In mode 00 both ports are affected. In mode 01 only ports whose mask bit is clear are affected. Any other mode affects no port.
- R7: Writing 1 to 0x0A bit 0 sets the power bit of the same set of affected ports.
- R8: The remote-wakeup bit (read at 0x09 bit 7) is set by writing 1 to 0x09 bit 7 and cleared by writing 1 to 0x0B bit 7. Writing 0 leaves it unchanged.
- R9: Bits 4:0 of each port's change byte are write-one-to-clear. Status byte 3 ignores writes and reads 0.
- R10: A `usb_reset` pulse loads both change bytes with 0x16. If a change-byte write falls in the same cycle, the reset wins.
- R11: A write to a port's status byte 1 sets power with bit 0 and removes power with bit 1 (clear wins if both are set). It acts only on the addressed port, and only in mode 01 with that port's mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Byte address to read |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| usb_reset | input | 1 | Bus-reset strobe, loads the change bytes |
| port_power | output | 2 | Power bit of each port |

## Verification
The USB-reset strobe and a register write can land in the same cycle and target the same change byte. The bench drives `usb_reset` together with a write of 0x1F to port 0's change byte, then reads both change bytes. Both must hold 0x16, showing the reset load takes precedence over the clear. A follow-up write to port 1's change byte must leave port 0 untouched.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;
  localparam int REG_CFG_A  = 0;
  localparam int REG_CFG_B  = 1;
  localparam int REG_HUB    = 2;
  localparam int REG_PORT0  = 3;
  localparam int CHG_W      = 5;
  localparam logic [CHG_W-1:0] CHG_RESET_VAL = 5'h16;
  localparam logic [CHG_W-1:0] CHG_PWR_CLR   = 5'h17;
  localparam logic [7:0] CFG_A1_KEEP = 8'h1B;
  typedef enum logic [1:0] {
    MODE_GLOBAL  = 2'b00,
    MODE_PERPORT = 2'b01,
    MODE_ALWAYS  = 2'b10,
    MODE_ALWAYS2 = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/hub_cfg_regs.sv
module hub_cfg_regs
  import hub_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a1_wr,
  input  logic                 a3_wr,
  input  logic                 b0_wr,
  input  logic                 b2_wr,
  input  logic                 wake_set,
  input  logic                 wake_clr,
  input  logic [7:0]           wr_data,
  output logic [7:0]           cfg_a1,
  output logic [1:0]           cfg_a3,
  output logic [NUM_PORTS-1:0] removable,
  output logic [NUM_PORTS-1:0] pmask,
  output logic                 wake
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_a1    <= '0;
      cfg_a3    <= '0;
      removable <= '0;
      pmask     <= '0;
      wake      <= 1'b0;
    end else begin
      if (a1_wr) cfg_a1 <= wr_data & CFG_A1_KEEP;
      if (a3_wr) cfg_a3 <= wr_data[1:0];
      if (b0_wr) removable <= wr_data[NUM_PORTS:1];
      if (b2_wr) pmask <= wr_data[NUM_PORTS:1];
      if (wake_set) wake <= 1'b1;
      else if (wake_clr) wake <= 1'b0;
    end
  end

  assert_wake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> wake);
  assert_wake_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !wake_set) |=> !wake);
endmodule

// File: rtl/hub_pwr_route.sv
module hub_pwr_route
  import hub_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic [1:0]           mode,
  input  logic [NUM_PORTS-1:0] pmask,
  input  logic                 hub_clr,
  input  logic                 hub_set,
  input  logic                 nps_wr,
  input  logic                 rmv_wr,
  input  logic [NUM_PORTS-1:0] rmv_data,
  input  logic [NUM_PORTS-1:0] port_pwr_wr,
  input  logic                 port_set_bit,
  input  logic                 port_clr_bit,
  output logic [NUM_PORTS-1:0] pwr_clr,
  output logic [NUM_PORTS-1:0] pwr_set,
  output logic [NUM_PORTS-1:0] force_on,
  output logic [NUM_PORTS-1:0] attach
);
  logic is_global, is_perport;
  assign is_global  = (mode == MODE_GLOBAL);
  assign is_perport = (mode == MODE_PERPORT);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_route
    logic affected, indiv, p_clr, p_set;
    assign affected = is_global | (is_perport & ~pmask[p]);
    assign indiv    = is_perport & pmask[p] & port_pwr_wr[p];
    assign p_clr    = (hub_clr & affected) | (indiv & port_clr_bit);
    assign p_set    = (hub_set & affected) | (indiv & port_set_bit);
    assign pwr_clr[p]  = p_clr;
    assign pwr_set[p]  = p_set & ~p_clr;
    assign force_on[p] = nps_wr;
    assign attach[p]   = rmv_wr & ~rmv_data[p];
  end
endmodule

// File: rtl/hub_port_ctrl.sv
module hub_port_ctrl
  import hub_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_reset,
  input  logic             pwr_clr,
  input  logic             pwr_set,
  input  logic             force_on,
  input  logic             attach,
  input  logic             chg_wr,
  input  logic [CHG_W-1:0] chg_clr,
  output logic             connected,
  output logic             powered,
  output logic [CHG_W-1:0] chg
);
  logic [CHG_W-1:0] chg_nxt;

  always_comb begin
    chg_nxt = chg;
    if (pwr_clr) chg_nxt = chg_nxt & ~CHG_PWR_CLR;
    if (attach && !connected) chg_nxt[0] = 1'b1;
    if (chg_wr) chg_nxt = chg_nxt & ~chg_clr;
    if (usb_reset) chg_nxt = CHG_RESET_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      connected <= 1'b0;
      powered   <= 1'b0;
      chg       <= '0;
    end else begin
      chg <= chg_nxt;
      if (pwr_clr) begin
        powered   <= 1'b0;
        connected <= 1'b0;
      end else if (pwr_set || force_on) begin
        powered <= 1'b1;
      end
      if (attach) connected <= 1'b1;
    end
  end

  assert_rst_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    usb_reset |=> (chg == CHG_RESET_VAL));
  assert_pwr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_clr && !usb_reset && !attach) |=> (!powered && !connected && ((chg & CHG_PWR_CLR) == '0)));
  assert_pwr_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_on || pwr_set) && !pwr_clr) |=> powered);
  assert_attach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    attach |=> connected);
  assert_attach_chg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (attach && !connected && !usb_reset && !chg_wr) |=> chg[0]);
endmodule

// File: rtl/hub_pwr_ctrl.sv
module hub_pwr_ctrl
  import hub_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 usb_reset,
  output logic [NUM_PORTS-1:0] port_power
);
  localparam int REG_W = ADDR_W - 2;

  logic [REG_W-1:0] wr_reg, rd_reg;
  logic [1:0]       wr_byte, rd_byte;
  assign wr_reg  = wr_addr[ADDR_W-1:2];
  assign wr_byte = wr_addr[1:0];
  assign rd_reg  = rd_addr[ADDR_W-1:2];
  assign rd_byte = rd_addr[1:0];

  logic hit_a, hit_b, hit_h;
  assign hit_a = wr_en && (wr_reg == REG_W'(REG_CFG_A));
  assign hit_b = wr_en && (wr_reg == REG_W'(REG_CFG_B));
  assign hit_h = wr_en && (wr_reg == REG_W'(REG_HUB));

  logic a1_wr, a3_wr, b0_wr, b2_wr, wake_set, wake_clr, hub_clr, hub_set;
  assign a1_wr    = hit_a && (wr_byte == 2'd1);
  assign a3_wr    = hit_a && (wr_byte == 2'd3);
  assign b0_wr    = hit_b && (wr_byte == 2'd0);
  assign b2_wr    = hit_b && (wr_byte == 2'd2);
  assign hub_clr  = hit_h && (wr_byte == 2'd0) && wr_data[0];
  assign wake_set = hit_h && (wr_byte == 2'd1) && wr_data[7];
  assign hub_set  = hit_h && (wr_byte == 2'd2) && wr_data[0];
  assign wake_clr = hit_h && (wr_byte == 2'd3) && wr_data[7];

  logic [NUM_PORTS-1:0] port_hit, port_pwr_wr, chg_wr;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign port_hit[p]    = wr_en && (wr_reg == REG_W'(REG_PORT0 + p));
    assign port_pwr_wr[p] = port_hit[p] && (wr_byte == 2'd1);
    assign chg_wr[p]      = port_hit[p] && (wr_byte == 2'd2);
  end

  logic [7:0]           cfg_a1;
  logic [1:0]           cfg_a3;
  logic [NUM_PORTS-1:0] removable, pmask;
  logic                 wake;

  hub_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .a1_wr(a1_wr), .a3_wr(a3_wr), .b0_wr(b0_wr), .b2_wr(b2_wr),
    .wake_set(wake_set), .wake_clr(wake_clr), .wr_data(wr_data),
    .cfg_a1(cfg_a1), .cfg_a3(cfg_a3), .removable(removable),
    .pmask(pmask), .wake(wake)
  );

  logic [NUM_PORTS-1:0] pwr_clr, pwr_set, force_on, attach;

  hub_pwr_route #(.NUM_PORTS(NUM_PORTS)) u_route (
    .mode(cfg_a1[1:0]), .pmask(pmask),
    .hub_clr(hub_clr), .hub_set(hub_set),
    .nps_wr(a1_wr && wr_data[1]),
    .rmv_wr(b0_wr), .rmv_data(wr_data[NUM_PORTS:1]),
    .port_pwr_wr(port_pwr_wr),
    .port_set_bit(wr_data[0]), .port_clr_bit(wr_data[1]),
    .pwr_clr(pwr_clr), .pwr_set(pwr_set),
    .force_on(force_on), .attach(attach)
  );

  logic [NUM_PORTS-1:0]            conn, pwr;
  logic [NUM_PORTS-1:0][CHG_W-1:0] chg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hub_port_ctrl u_port (
      .clk(clk), .rst_n(rst_n), .usb_reset(usb_reset),
      .pwr_clr(pwr_clr[p]), .pwr_set(pwr_set[p]),
      .force_on(force_on[p]), .attach(attach[p]),
      .chg_wr(chg_wr[p]), .chg_clr(wr_data[CHG_W-1:0]),
      .connected(conn[p]), .powered(pwr[p]), .chg(chg[p])
    );
  end

  assign port_power = pwr;

  always_comb begin
    rd_data = 8'h00;
    unique case (rd_reg)
      REG_W'(REG_CFG_A): begin
        case (rd_byte)
          2'd0:    rd_data = 8'(NUM_PORTS);
          2'd1:    rd_data = cfg_a1;
          2'd3:    rd_data = {6'b0, cfg_a3};
          default: rd_data = 8'h00;
        endcase
      end
      REG_W'(REG_CFG_B): begin
        if (rd_byte == 2'd0) rd_data[NUM_PORTS:1] = removable;
        if (rd_byte == 2'd2) rd_data[NUM_PORTS:1] = pmask;
      end
      REG_W'(REG_HUB): begin
        if (rd_byte == 2'd1) rd_data[7] = wake;
      end
      default: begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (rd_reg == REG_W'(REG_PORT0 + p)) begin
            case (rd_byte)
              2'd0:    rd_data[0] = conn[p];
              2'd1:    rd_data[0] = pwr[p];
              2'd2:    rd_data[CHG_W-1:0] = chg[p];
              default: rd_data = 8'h00;
            endcase
          end
        end
      end
    endcase
  end

  assert_glob_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_clr && cfg_a1[1:0] == MODE_GLOBAL) |=> (port_power == '0));
  assert_nps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a1_wr && wr_data[1]) |=> (port_power == '1));
endmodule

// File: tb/hub_pwr_ctrl_test.sv
module hub_pwr_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       usb_reset = 1'b0;
  logic [1:0] port_power;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hub_pwr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .usb_reset(usb_reset), .port_power(port_power)
  );

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_reset(input bit with_wr, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    usb_reset = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk);
    usb_reset = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_pwr(input logic [1:0] exp, input string req);
    #1;
    checks++;
    if (port_power !== exp) begin
      errors++;
      $display("FAIL %s port_power actual=%b expected=%b", req, port_power, exp);
    end
  endtask

  task automatic t_reset;
    chk(5'h00, 8'h02, "R1"); chk(5'h01, 8'h00, "R1"); chk(5'h04, 8'h00, "R1");
    chk(5'h09, 8'h00, "R1"); chk(5'h0C, 8'h00, "R1"); chk(5'h0D, 8'h00, "R1");
    chk(5'h0E, 8'h00, "R1"); chk(5'h11, 8'h00, "R1"); chk_pwr(2'b00, "R1");
  endtask

  task automatic t_cfg_a;
    wr(5'h01, 8'hE5); chk(5'h01, 8'h01, "R2"); chk(5'h0D, 8'h00, "R2");
    wr(5'h03, 8'hFF); chk(5'h03, 8'h03, "R2");
    wr(5'h00, 8'hFF); chk(5'h00, 8'h02, "R2");
    wr(5'h02, 8'hFF); chk(5'h02, 8'h00, "R2");
    wr(5'h01, 8'h00); wr(5'h03, 8'h00);
  endtask

  task automatic t_cfg_b;
    wr(5'h04, 8'hFF); chk(5'h04, 8'h06, "R4");
    chk(5'h0C, 8'h00, "R4"); chk(5'h10, 8'h00, "R4");
    wr(5'h06, 8'hF9); chk(5'h06, 8'h00, "R4");
    wr(5'h06, 8'hFF); chk(5'h06, 8'h06, "R4");
    wr(5'h05, 8'hFF); chk(5'h05, 8'h00, "R4");
    wr(5'h07, 8'hFF); chk(5'h07, 8'h00, "R4");
    wr(5'h06, 8'h00);
  endtask

  task automatic t_attach;
    wr(5'h04, 8'h04);
    chk(5'h0C, 8'h01, "R5"); chk(5'h0E, 8'h01, "R5");
    chk(5'h10, 8'h00, "R5"); chk(5'h12, 8'h00, "R5");
    wr(5'h0E, 8'h01); chk(5'h0E, 8'h00, "R9");
    wr(5'h04, 8'h04); chk(5'h0C, 8'h01, "R5"); chk(5'h0E, 8'h00, "R5");
    wr(5'h04, 8'h00);
    chk(5'h10, 8'h01, "R5"); chk(5'h12, 8'h01, "R5"); chk(5'h0E, 8'h00, "R5");
  endtask

  task automatic t_global;
    wr(5'h0A, 8'h01);
    chk(5'h0D, 8'h01, "R7"); chk(5'h11, 8'h01, "R7"); chk_pwr(2'b11, "R7");
    pulse_reset(1'b0, 5'h00, 8'h00);
    chk(5'h0E, 8'h16, "R10"); chk(5'h12, 8'h16, "R10");
    wr(5'h08, 8'h01);
    chk(5'h0D, 8'h00, "R6"); chk(5'h11, 8'h00, "R6");
    chk(5'h0C, 8'h00, "R6"); chk(5'h10, 8'h00, "R6");
    chk(5'h0E, 8'h00, "R6"); chk(5'h12, 8'h00, "R6");
    wr(5'h0A, 8'h02); chk(5'h0D, 8'h00, "R7");
  endtask

  task automatic t_perport;
    wr(5'h01, 8'h01); wr(5'h06, 8'h04);
    wr(5'h0A, 8'h01); chk(5'h0D, 8'h01, "R7"); chk(5'h11, 8'h00, "R7");
    wr(5'h11, 8'h01); chk(5'h11, 8'h01, "R11");
    wr(5'h0D, 8'h02); chk(5'h0D, 8'h01, "R11");
    wr(5'h08, 8'h01); chk(5'h0D, 8'h00, "R6"); chk(5'h11, 8'h01, "R6");
    wr(5'h11, 8'h03); chk(5'h11, 8'h00, "R11"); chk(5'h0D, 8'h00, "R11");
    wr(5'h01, 8'h00);
    wr(5'h11, 8'h01); chk(5'h11, 8'h00, "R11");
    wr(5'h06, 8'h00);
  endtask

  task automatic t_nps;
    wr(5'h01, 8'h02);
    chk(5'h01, 8'h02, "R3"); chk(5'h0D, 8'h01, "R3"); chk(5'h11, 8'h01, "R3");
    wr(5'h08, 8'h01); chk_pwr(2'b11, "R6");
    wr(5'h01, 8'h00); wr(5'h08, 8'h01); chk_pwr(2'b00, "R6");
  endtask

  task automatic t_wake;
    wr(5'h09, 8'h80); chk(5'h09, 8'h80, "R8");
    wr(5'h09, 8'h00); chk(5'h09, 8'h80, "R8");
    wr(5'h0B, 8'h00); chk(5'h09, 8'h80, "R8");
    wr(5'h0B, 8'h80); chk(5'h09, 8'h00, "R8");
  endtask

  task automatic t_change;
    pulse_reset(1'b0, 5'h00, 8'h00); chk(5'h0E, 8'h16, "R10");
    wr(5'h0E, 8'h06); chk(5'h0E, 8'h10, "R9");
    wr(5'h0F, 8'hFF); chk(5'h0F, 8'h00, "R9"); chk(5'h0E, 8'h10, "R9");
    pulse_reset(1'b1, 5'h0E, 8'h1F);
    chk(5'h0E, 8'h16, "R10"); chk(5'h12, 8'h16, "R10");
    wr(5'h12, 8'h1F); chk(5'h12, 8'h00, "R9"); chk(5'h0E, 8'h16, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_cfg_a(); t_cfg_b(); t_attach(); t_global();
    t_perport(); t_nps(); t_wake(); t_change();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule